// File: doc/BRIEF.md
# Serial Shift Register with Status Readback

This block is the serial front end of a multi-output switch driver. A host clocks a 17-bit word in on a serial data pin, one bit per rising edge of a serial clock, most significant bit first, while the bit falling off the top of the register appears on a serial data output. A latch strobe then acts on the word. When the top bit (the select bit) is 0, the 16 lower bits are copied into a 16-bit on/off latch that drives the outputs. In the same event, a 16-bit status word from a capture unit overwrites those lower bits, so the next shift cycle reads the status back out. When the select bit is 1, the register is left as it is and a one-cycle strobe tells a neighbouring control latch to take the word.

The serial clock and the latch strobe are sampled on the system clock through two-stage synchronizers, and their rising edges are detected from the registered samples. A latch strobe is accepted only if at least one bit has been shifted in since the last accepted strobe. The status can therefore be refreshed without changing the outputs: the host writes the current on/off pattern again and pulses the strobe.

Top module: `serial_latch_port`

## Requirements
- R1: After reset the on/off latch is all zeros (all outputs off), the serial output is 0 and the control strobe is low.
- R2: Each synchronized rising edge of the serial clock shifts the register left by one, taking the serial input into bit 0. The serial output always shows bit 16, so a 17-bit word leaves in the order it entered, most significant bit first.
- R3: An accepted latch rising edge with bit 16 = 0 copies bits 15..0 into the on/off latch.
- R4: In that same event, the status word replaces bits 15..0 of the register. Bit 16 keeps its value, so the next 17 bits shifted out are a 0 followed by the status word, most significant bit first.
- R5: An accepted latch rising edge with bit 16 = 1 leaves the register and the on/off latch unchanged.
- R6: A latch rising edge with no serial-clock edge since the last accepted one is ignored. The on/off latch keeps its value and no new status is loaded.
- R7: Writing the on/off pattern that is already latched and then pulsing the latch leaves the outputs unchanged and loads the current status word into the register.
- R8: The control strobe pulses high for exactly one system clock per accepted latch edge with bit 16 = 1, and never for a status-load event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock, asynchronous to clk |
| lat_strobe | input | 1 | Latch strobe, asynchronous to clk |
| status_word | input | 16 | Status word from the capture unit |
| ser_out | output | 1 | Serial data out (register bit 16) |
| onoff | output | 16 | On/off latch, bit n drives output n |
| ctrl_load | output | 1 | One-cycle strobe for a select-bit-1 word |

## Verification
A walking-one sweep over all 16 data positions, each with its own computed status word, shows whether the copy to the on/off latch and the status load each use the right bit positions, and whether bit 16 survives the load. Plain write-and-read words with no latch tell the shift order apart from the latch actions. Repeated strobes with no shifting in between, rewrites of the pattern already latched, and words with the select bit set separate the three latch outcomes: ignored, status refresh, and control strobe.

// File: rtl/slp_pkg.sv
package slp_pkg;
  // Action taken on a latch rising edge
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_CTRL = 2'd2
  } lat_act_e;
endpackage

// File: rtl/slp_edge_sync.sv
module slp_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[DEPTH-2:0], async_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end

    assign level_o[g] = pipe_q[STAGES-1];
    assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/slp_shift_core.sv
module slp_shift_core
  import slp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sin_s,
  input  logic          sclk_rise,
  input  logic          lat_rise,
  input  logic [DW-1:0] status_i,
  output logic          sout_o,
  output logic [DW-1:0] onoff_o,
  output logic          ctrl_o
);
  localparam int SW = DW + 1;

  logic [SW-1:0] sr_q, sr_d;
  logic [DW-1:0] onoff_q, onoff_d;
  logic          fresh_q, fresh_d;
  logic          ctrl_q, ctrl_d;
  logic          sr_en, onoff_en, fresh_en;
  lat_act_e      act;

  // Latch decode: an edge counts only when new bits arrived since the last one
  always_comb begin
    act = ACT_NONE;
    if (lat_rise && fresh_q) act = sr_q[SW-1] ? ACT_CTRL : ACT_LOAD;
  end

  // Next state; an accepted latch takes priority over a coincident shift
  always_comb begin
    sr_d     = sr_q;
    onoff_d  = onoff_q;
    fresh_d  = fresh_q;
    ctrl_d   = 1'b0;
    sr_en    = 1'b0;
    onoff_en = 1'b0;
    fresh_en = 1'b0;
    unique case (act)
      ACT_LOAD: begin
        onoff_d  = sr_q[DW-1:0];
        onoff_en = 1'b1;
        sr_d     = {sr_q[SW-1], status_i};
        sr_en    = 1'b1;
        fresh_d  = 1'b0;
        fresh_en = 1'b1;
      end
      ACT_CTRL: begin
        ctrl_d   = 1'b1;
        fresh_d  = 1'b0;
        fresh_en = 1'b1;
      end
      default: begin
        if (sclk_rise) begin
          sr_d     = {sr_q[SW-2:0], sin_s};
          sr_en    = 1'b1;
          fresh_d  = 1'b1;
          fresh_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      onoff_q <= '0;
      fresh_q <= 1'b0;
      ctrl_q  <= 1'b0;
    end else begin
      if (sr_en)    sr_q    <= sr_d;
      if (onoff_en) onoff_q <= onoff_d;
      if (fresh_en) fresh_q <= fresh_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign sout_o  = sr_q[SW-1];
  assign onoff_o = onoff_q;
  assign ctrl_o  = ctrl_q;

  // R2: a lone shift edge moves the synchronized input into bit 0
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !lat_rise) |=> (sr_q[0] == $past(sin_s)) && (sr_q[SW-1] == $past(sr_q[SW-2])));

  // R3: on/off latch moves only after an accepted select-0 latch edge
  p_onoff_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_rise && fresh_q && !sr_q[SW-1]) |=> $stable(onoff_q));

  // R4: status load keeps bit 16
  p_msb_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && fresh_q) |=> $stable(sr_q[SW-1]));

  // R5: select-1 latch leaves register and outputs untouched
  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && fresh_q && sr_q[SW-1]) |=> $stable(sr_q) && $stable(onoff_q));

  // R6: a stale latch edge changes nothing
  p_stale_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !fresh_q && !sclk_rise) |=> $stable(sr_q) && $stable(onoff_q));

  // R8: control strobe follows only an accepted select-1 edge, one cycle wide
  p_ctrl_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q |-> $past(lat_rise && fresh_q && sr_q[SW-1]));
  p_ctrl_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q |=> !ctrl_q);
endmodule

// File: rtl/serial_latch_port.sv
module serial_latch_port #(
  parameter int DW       = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  input  logic          ser_clk,
  input  logic          lat_strobe,
  input  logic [DW-1:0] status_word,
  output logic          ser_out,
  output logic [DW-1:0] onoff,
  output logic          ctrl_load
);
  localparam int NSIG = 3;
  localparam int I_SIN = 0;
  localparam int I_SCK = 1;
  localparam int I_LAT = 2;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [NSIG-1:0] raw_in, lvl, rise;
  assign raw_in = {lat_strobe, ser_clk, ser_in};

  slp_edge_sync #(.N(NSIG), .STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (raw_in),
    .level_o  (lvl),
    .rise_o   (rise)
  );

  slp_shift_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sin_s     (lvl[I_SIN]),
    .sclk_rise (rise[I_SCK]),
    .lat_rise  (rise[I_LAT]),
    .status_i  (status_word),
    .sout_o    (ser_out),
    .onoff_o   (onoff),
    .ctrl_o    (ctrl_load)
  );
endmodule

// File: tb/sim_serial_latch_port.sv
module sim_serial_latch_port;
  localparam int CLK_P = 10;
  localparam int HOLD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_in = 1'b0;
  logic        ser_clk = 1'b0;
  logic        lat_strobe = 1'b0;
  logic [15:0] status_word = '0;
  logic        ser_out;
  logic [15:0] onoff;
  logic        ctrl_load;

  int n_run = 0;
  int n_fail = 0;
  int strobe_cnt = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serial_latch_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_clk(ser_clk),
    .lat_strobe(lat_strobe), .status_word(status_word),
    .ser_out(ser_out), .onoff(onoff), .ctrl_load(ctrl_load)
  );

  always @(posedge clk) if (ctrl_load) strobe_cnt <= strobe_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_in(input logic b);
    @(negedge clk) ser_in = b;
    repeat (HOLD) @(negedge clk);
    ser_clk = 1'b1;
    repeat (HOLD) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic write_word(input logic [16:0] w);
    for (int i = 16; i >= 0; i--) bit_in(w[i]);
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic read_word(output logic [16:0] r);
    for (int i = 16; i >= 0; i--) begin
      @(negedge clk) r[i] = ser_out;
      bit_in(1'b0);
    end
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic lat_pulse();
    @(negedge clk) lat_strobe = 1'b1;
    repeat (HOLD) @(negedge clk);
    lat_strobe = 1'b0;
    repeat (HOLD + 2) @(negedge clk);
  endtask

  function automatic logic [15:0] stat_of(input int k);
    logic [15:0] v;
    v = 16'(k) * 16'h1F35 + 16'h6A91;
    return {v[7:0], v[15:8]} ^ 16'h3C0F;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [16:0] r;
    logic [15:0] d, d2, s_old, s_new;
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check("R1 onoff", 32'(onoff), 32'h0);
    check("R1 ser_out", 32'(ser_out), 32'h0);
    check("R1 ctrl_load", 32'(strobe_cnt), 32'h0);

    // R2 pure shift, MSB first, no latch
    for (int k = 0; k < 4; k++) begin
      logic [16:0] w;
      w = 17'(k * 17'h0B6D3 + 17'h1A5A5);
      write_word(w);
      read_word(r);
      check("R2 shift order", 32'(r), 32'(w));
      check("R2 no latch onoff", 32'(onoff), 32'h0);
    end

    // R3/R4 walking one over every data position
    for (int i = 0; i < 16; i++) begin
      d = 16'(1) << i;
      status_word = stat_of(i);
      write_word({1'b0, d});
      lat_pulse();
      check("R3 onoff copy", 32'(onoff), 32'(d));
      read_word(r);
      check("R4 status readback", 32'(r), 32'({1'b0, stat_of(i)}));
    end
    check("R8 no strobe on load", 32'(strobe_cnt), 32'h0);

    // R6 stale latch edge
    d2 = 16'hC3A5;
    s_old = 16'h5E17;
    status_word = s_old;
    write_word({1'b0, d2});
    lat_pulse();
    check("R3 onoff copy", 32'(onoff), 32'(d2));
    status_word = 16'hFFFF ^ s_old;
    lat_pulse();
    lat_pulse();
    check("R6 onoff kept", 32'(onoff), 32'(d2));
    read_word(r);
    check("R6 status not reloaded", 32'(r), 32'({1'b0, s_old}));

    // R7 rewrite same pattern to refresh status
    s_new = 16'h92B4;
    status_word = s_new;
    write_word({1'b0, d2});
    lat_pulse();
    check("R7 onoff unchanged", 32'(onoff), 32'(d2));
    read_word(r);
    check("R7 status refreshed", 32'(r), 32'({1'b0, s_new}));

    // R5/R8 select bit set
    for (int k = 0; k < 3; k++) begin
      logic [16:0] w;
      w = {1'b1, 16'(k * 16'h4D2B + 16'h0F0F)};
      sc = strobe_cnt;
      write_word(w);
      lat_pulse();
      check("R5 onoff unchanged", 32'(onoff), 32'(d2));
      check("R8 one strobe", 32'(strobe_cnt - sc), 32'd1);
      read_word(r);
      check("R5 register unchanged", 32'(r), 32'(w));
    end
    // R8 stale latch after control word gives no strobe
    write_word({1'b1, 16'h1234});
    lat_pulse();
    sc = strobe_cnt;
    lat_pulse();
    check("R8 stale no strobe", 32'(strobe_cnt - sc), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule